// File: doc/BRIEF.md
# Transmit AIS Generator with Clock-Loss Monitor

This block sits at the end of a line transmitter's serial data path. On each bit boundary it emits one bit on the line. The bit comes either from the local transmit data input or from the receiver's data during remote line loopback. When the alarm indication signal is in force, the block sends a continuous stream of unframed ones in place of that data. AIS can be requested by a control pin. It is also raised automatically when the transmit clock stops.

All logic runs on a free-running reference clock. The transmit clock and the alternate AIS clock arrive as asynchronous inputs. Each passes through a two-flop synchronizer followed by a rising-edge detector. A monitor counts reference cycles between transmit-clock edges. When the gap grows too long, the monitor declares loss, switches bit timing to the alternate clock and forces AIS. It releases both once enough consecutive edges have returned. Glitch-free switching of the analog clock is outside this block; the choice is reported on a select output.

A separate local-loopback output carries the chosen source data on the same bit boundaries, and AIS never overrides it. The line bits are timed by the line clock and cannot wait, so the data pins are plain bit-serial pins and have no valid/ready handshake. There is no back-pressure.

Top module: `ais_txgen`

## Requirements
- R1: While `rst_n` is low, and until the first bit boundary after it rises, all of the following hold: `line_data`=0, `lb_data`=0, `ais_active`=0, `clk_sel_alt`=0, `clk_lost`=0 and `irq_loss`=0.
- R2: A bit boundary is a rising edge of the selected clock as seen at the synchronizer output. A level sampled on reference edge k produces a boundary at reference edge k+2 when the level sampled on edge k-1 was low. At each boundary, `line_data` and `lb_data` register the source bit present at that edge. Between boundaries they hold their value.
- R3: `src_rlb`=0 selects `tx_data` as the source bit, and `src_rlb`=1 selects `rlb_data`.
- R4: AIS is requested when `ais_force`=1 or `clk_lost`=1. At a boundary where AIS is requested, `line_data` becomes 1, whichever source is selected.
- R5: `ais_active` changes only at bit boundaries. It then takes the value of the AIS request at that edge.
- R6: `lb_data` always carries the source bit and is never forced by AIS. Whenever `ais_active`=0, it equals `line_data`.
- R7: `clk_lost` rises after LOSS_CYC consecutive reference cycles (default 32) in which no transmit-clock edge was detected.
- R8: While `clk_lost`=1, it clears on the RECOV_EDGES-th detected transmit edge (default 8). A gap of LOSS_CYC cycles without an edge restarts that count.
- R9: `clk_sel_alt`=1 whenever `alt_clk_force`=1 or `clk_lost`=1, and bit boundaries are then taken from `ais_clk`.
- R10: `irq_loss` is set on every transition of `clk_lost` from 0 to 1. It stays set until `irq_clr` is high at an edge. A new loss on the same edge as `irq_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clk | input | 1 | Normal transmit clock, asynchronous |
| ais_clk | input | 1 | Alternate AIS clock, asynchronous |
| tx_data | input | 1 | Local transmit data bit |
| rlb_data | input | 1 | Receiver data for remote line loopback |
| src_rlb | input | 1 | Static source select, 1 = receiver data |
| ais_force | input | 1 | Manual AIS request |
| alt_clk_force | input | 1 | Manual selection of the alternate clock |
| irq_clr | input | 1 | Clears the sticky loss flag |
| line_data | output | 1 | Bit sent to the line |
| lb_data | output | 1 | Bit for local digital loopback, unaffected by AIS |
| ais_active | output | 1 | AIS currently being sent |
| clk_sel_alt | output | 1 | Alternate clock selected |
| clk_lost | output | 1 | Transmit clock loss status |
| irq_loss | output | 1 | Sticky flag set on entry to loss |

## Verification
The hardest state to reach from the ports is a recovery that is interrupted. In that case the transmit clock returns for fewer than RECOV_EDGES edges and then stops again. The count must restart while `clk_lost` stays high and `irq_loss` must not be raised again. The stimulus stops `tx_clk` until loss is declared, then runs a few edges and stops again for longer than LOSS_CYC cycles. Only after that does it restart the clock for good. Both clocks are toggled on reference-clock falling edges, so every boundary lands on a known reference edge. A behavioural model with a history queue of sampled levels can therefore predict each output on every cycle.

// File: rtl/ais_pkg.sv
package ais_pkg;
  typedef enum logic {SRC_TX = 1'b0, SRC_RLB = 1'b1} src_sel_e;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/ais_edge_sync.sv
module ais_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int TAPS = STAGES + 1;
  logic [TAPS-1:0] tap;

  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tap[g] <= 1'b0;
        else        tap[g] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tap[g] <= 1'b0;
        else        tap[g] <= tap[g-1];
    end
  end

  assign rise = tap[STAGES-1] & ~tap[STAGES];
endmodule

// File: rtl/ais_clk_loss_mon.sv
module ais_clk_loss_mon #(
  parameter int LOSS_CYC    = 32,
  parameter int RECOV_EDGES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  input  logic irq_clr,
  output logic lost,
  output logic irq
);
  localparam int GAP_W = ais_pkg::cnt_width(LOSS_CYC);
  localparam int REC_W = ais_pkg::cnt_width(RECOV_EDGES);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(LOSS_CYC - 1);
  localparam logic [REC_W-1:0] REC_MAX = REC_W'(RECOV_EDGES - 1);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             lost_d;

  always_comb begin
    gap_d  = gap_q;
    rec_d  = rec_q;
    lost_d = lost;
    if (edge_seen) begin
      gap_d = '0;
      if (lost) begin
        if (rec_q == REC_MAX) begin
          lost_d = 1'b0;
          rec_d  = '0;
        end else begin
          rec_d = rec_q + 1'b1;
        end
      end
    end else if (gap_q == GAP_MAX) begin
      lost_d = 1'b1;
      rec_d  = '0;
    end else begin
      gap_d = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      rec_q <= '0;
      lost  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      gap_q <= gap_d;
      rec_q <= rec_d;
      lost  <= lost_d;
      if (lost_d && !lost) irq <= 1'b1;
      else if (irq_clr)    irq <= 1'b0;
    end
  end

  AST_LOSS_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> !$past(edge_seen)); // R7
  AST_CLEAR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost) |-> $past(edge_seen)); // R8
  AST_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> irq); // R10
endmodule

// File: rtl/ais_bit_gate.sv
module ais_bit_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic ais_req,
  input  logic src_bit,
  output logic line_data,
  output logic lb_data,
  output logic ais_active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_data  <= 1'b0;
      lb_data    <= 1'b0;
      ais_active <= 1'b0;
    end else if (bit_stb) begin
      ais_active <= ais_req;
      lb_data    <= src_bit;
      line_data  <= ais_req | src_bit;
    end
  end

  AST_AIS_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(ais_active)); // R5
  AST_AIS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ais_active |-> line_data); // R4
endmodule

// File: rtl/ais_txgen.sv
module ais_txgen #(
  parameter int LOSS_CYC    = 32,
  parameter int RECOV_EDGES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic tx_clk,
  input  logic ais_clk,
  input  logic tx_data,
  input  logic rlb_data,
  input  logic src_rlb,
  input  logic ais_force,
  input  logic alt_clk_force,
  input  logic irq_clr,
  output logic line_data,
  output logic lb_data,
  output logic ais_active,
  output logic clk_sel_alt,
  output logic clk_lost,
  output logic irq_loss
);
  import ais_pkg::*;

  logic     tx_rise, alt_rise, bit_stb, ais_req, src_bit;
  src_sel_e src_sel;

  ais_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_tx (
    .clk(ref_clk), .rst_n(rst_n), .async_in(tx_clk), .rise(tx_rise));
  ais_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_alt (
    .clk(ref_clk), .rst_n(rst_n), .async_in(ais_clk), .rise(alt_rise));

  ais_clk_loss_mon #(.LOSS_CYC(LOSS_CYC), .RECOV_EDGES(RECOV_EDGES)) i_mon (
    .clk(ref_clk), .rst_n(rst_n), .edge_seen(tx_rise), .irq_clr(irq_clr),
    .lost(clk_lost), .irq(irq_loss));

  assign src_sel     = src_sel_e'(src_rlb);
  assign src_bit     = (src_sel == SRC_RLB) ? rlb_data : tx_data;
  assign clk_sel_alt = alt_clk_force | clk_lost;
  assign bit_stb     = clk_sel_alt ? alt_rise : tx_rise;
  assign ais_req     = ais_force | clk_lost;

  ais_bit_gate i_gate (
    .clk(ref_clk), .rst_n(rst_n), .bit_stb(bit_stb), .ais_req(ais_req),
    .src_bit(src_bit), .line_data(line_data), .lb_data(lb_data),
    .ais_active(ais_active));

  AST_LOSS_FORCES_AIS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_lost && bit_stb |=> ais_active); // R9
  AST_LB_MATCHES_LINE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !ais_active |-> (lb_data == line_data)); // R6
  AST_NO_STB_HOLDS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !bit_stb |=> $stable(line_data) && $stable(lb_data)); // R2
endmodule

// File: tb/test_ais_txgen.sv
module test_ais_txgen;
  localparam int LOSS = 32;
  localparam int RECOV = 8;

  logic ref_clk = 1'b0, rst_n = 1'b0;
  logic tx_clk = 1'b0, ais_clk = 1'b0, tx_data = 1'b0, rlb_data = 1'b0;
  logic src_rlb = 1'b0, ais_force = 1'b0, alt_clk_force = 1'b0, irq_clr = 1'b0;
  logic line_data, lb_data, ais_active, clk_sel_alt, clk_lost, irq_loss;

  int errors = 0, checks = 0;
  bit tx_run = 1'b1, done = 1'b0;
  bit saw_lost = 0, saw_recover = 0, saw_alt_manual = 0, saw_rlb = 0;

  always #5 ref_clk = ~ref_clk;

  ais_txgen i_ais_txgen (
    .ref_clk(ref_clk), .rst_n(rst_n), .tx_clk(tx_clk), .ais_clk(ais_clk),
    .tx_data(tx_data), .rlb_data(rlb_data), .src_rlb(src_rlb),
    .ais_force(ais_force), .alt_clk_force(alt_clk_force), .irq_clr(irq_clr),
    .line_data(line_data), .lb_data(lb_data), .ais_active(ais_active),
    .clk_sel_alt(clk_sel_alt), .clk_lost(clk_lost), .irq_loss(irq_loss));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // clock and data drivers, on falling edges
  int tx_div = 0, alt_div = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge ref_clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_data  <= lfsr[0];
    rlb_data <= lfsr[7];
    if (tx_run) begin
      tx_div = tx_div + 1;
      if (tx_div == 2) begin tx_div = 0; tx_clk <= ~tx_clk; end
    end
    alt_div = alt_div + 1;
    if (alt_div == 3) begin alt_div = 0; ais_clk <= ~ais_clk; end
  end

  // behavioural reference model, updated on rising edges
  logic q_tx[$], q_alt[$];
  int   m_gap, m_rec;
  logic m_lost, m_irq, m_ais, m_line, m_lb;
  always @(posedge ref_clk) begin
    if (!rst_n) begin
      q_tx = {1'b0, 1'b0, 1'b0}; q_alt = {1'b0, 1'b0, 1'b0};
      m_gap = 0; m_rec = 0; m_lost = 0; m_irq = 0; m_ais = 0; m_line = 0; m_lb = 0;
    end else begin
      logic r_tx, r_alt, alt, stb, req, src, lost_new;
      // queue holds levels sampled at edges n-3, n-2, n-1
      r_tx  = q_tx[1] & ~q_tx[0];
      r_alt = q_alt[1] & ~q_alt[0];
      void'(q_tx.pop_front()); q_tx.push_back(tx_clk);
      void'(q_alt.pop_front()); q_alt.push_back(ais_clk);
      alt = alt_clk_force | m_lost;
      stb = alt ? r_alt : r_tx;
      req = ais_force | m_lost;
      src = src_rlb ? rlb_data : tx_data;
      if (stb) begin m_ais = req; m_lb = src; m_line = req ? 1'b1 : src; end
      lost_new = m_lost;
      if (r_tx) begin
        m_gap = 0;
        if (m_lost) begin
          if (m_rec == RECOV - 1) begin lost_new = 0; m_rec = 0; end
          else m_rec++;
        end
      end else if (m_gap == LOSS - 1) begin
        lost_new = 1; m_rec = 0;
      end else m_gap++;
      if (lost_new && !m_lost) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if (m_lost && !lost_new) saw_recover = 1;
      if (lost_new) saw_lost = 1;
      m_lost = lost_new;
    end
  end

  // compare on every falling edge
  always @(negedge ref_clk) begin
    if (rst_n && !done) begin
      string tl;
      tl = m_ais ? "R4" : (src_rlb ? "R3" : "R2");
      if (src_rlb) saw_rlb = 1;
      if (alt_clk_force && !m_lost && clk_sel_alt) saw_alt_manual = 1;
      check(tl, "line_data", line_data, m_line);
      check("R6", "lb_data", lb_data, m_lb);
      check("R5", "ais_active", ais_active, m_ais);
      check("R9", "clk_sel_alt", clk_sel_alt, alt_clk_force | m_lost);
      check(m_lost ? "R7" : "R8", "clk_lost", clk_lost, m_lost);
      check("R10", "irq_loss", irq_loss, m_irq);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    // R1: reset state
    check("R1", "reset line_data", line_data, 1'b0);
    check("R1", "reset lb_data", lb_data, 1'b0);
    check("R1", "reset ais_active", ais_active, 1'b0);
    check("R1", "reset clk_sel_alt", clk_sel_alt, 1'b0);
    check("R1", "reset clk_lost", clk_lost, 1'b0);
    check("R1", "reset irq_loss", irq_loss, 1'b0);
    rst_n = 1'b1;
    wait_cyc(60);                            // R2 normal data
    src_rlb = 1'b1; wait_cyc(60);            // R3 remote loopback source
    ais_force = 1'b1; wait_cyc(40);          // R4 manual AIS over loopback data
    src_rlb = 1'b0; wait_cyc(30);            // R4 manual AIS over local data
    ais_force = 1'b0; wait_cyc(30);          // R5 release on boundary
    tx_run = 1'b0; wait_cyc(50);             // R7 loss, auto AIS, alternate clock
    irq_clr = 1'b1; wait_cyc(1); irq_clr = 1'b0; wait_cyc(5);   // R10 clear
    tx_run = 1'b1; wait_cyc(18);             // R8 partial recovery
    tx_run = 1'b0; wait_cyc(45);             // R8 count restarts
    tx_run = 1'b1; wait_cyc(60);             // R8 full recovery
    alt_clk_force = 1'b1; wait_cyc(40);      // R9 manual alternate clock
    alt_clk_force = 1'b0; wait_cyc(30);
    check("R7", "loss reached", saw_lost, 1'b1);
    check("R8", "recovery reached", saw_recover, 1'b1);
    check("R9", "manual alt select seen", saw_alt_manual, 1'b1);
    check("R3", "loopback source exercised", saw_rlb, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule